// File: doc/BRIEF.md
# Nine-Candidate Sub-Sampled SAD Engine

This block scores nine candidate positions for one 16x16 block of 8-bit pixels in a single pass, as part of a motion search. The block and the reference area are split into four interleaved phases: lane k takes the pixels whose (row mod 2, column mod 2) phase is (k/2, k mod 2). Each lane therefore carries 64 pixel pairs per candidate. On every accepted beat, each lane receives one current pixel, plus one reference pixel for each of the nine candidates. Nine processing elements per lane, 36 in all, each add one absolute difference into a 14-bit partial sum.

A start strobe opens a pass. It clears all partial sums and captures a per-candidate invalid mask. The 64th accepted beat closes the pass. At that point the four lane partial sums of each candidate are added into a 16-bit cost. Candidates marked invalid are forced to the all-ones cost. A nine-way minimum search then reports the index and cost of the winner, and a one-cycle valid pulse marks the result. Fetch addressing and search control sit outside the block.

Top module: `sad9_array`

## Requirements
- R1: After reset, `res_valid` is 0, every cost output is 0, `best_idx` is 0 and `best_cost` is 0.
- R2: The cost of candidate c, in bits [16c+15:16c] of `cost_flat`, equals the sum over all four lanes and all 64 accepted beats of |cur − ref|. Lane l's current pixel is in `cur_pix[8l+7:8l]`. Its reference pixel for candidate c is in `ref_pix[8(9l+c)+7:8(9l+c)]`.
- R3: `res_valid` is high for exactly one cycle. It rises on the second rising edge after the edge that accepts the 64th beat of a pass.
- R4: While `res_valid` is high, `best_idx` (0..8) and `best_cost` name the lowest cost. When costs tie, the lowest index wins.
- R5: A candidate whose bit in `cand_inv` was 1 in the start cycle reports cost 16'hFFFF and competes with that value.
- R6: A start strobe clears all partial sums, including in the middle of a pass. A beat presented in the same cycle as start is not accepted.
- R7: A beat is accepted only when `in_valid` is 1 and start is 0. Beats are ignored after reset until the first start, and after the 64th beat until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Opens a pass; clears partial sums, latches cand_inv |
| cand_inv | input | 9 | Per-candidate invalid mask, sampled with start |
| in_valid | input | 1 | Pixel beat present |
| cur_pix | input | 32 | One current pixel per lane |
| ref_pix | input | 288 | Nine reference pixels per lane, lane-major |
| res_valid | output | 1 | One-cycle result strobe |
| cost_flat | output | 144 | Nine 16-bit costs, candidate 0 in the low bits |
| best_idx | output | 4 | Index of the minimum cost |
| best_cost | output | 16 | Minimum cost |

## Verification
The bench accepts beats at the same rising edges as the block. A behavioural model counts two more edges from the edge that takes the 64th beat, and expects the valid pulse there. On every falling edge the model's expected strobe is compared with `res_valid`, so a pulse that comes one cycle early or late fails at once. The nine costs and the winner are compared only in the cycle the model marks valid. The patterns are chosen so that ties, invalid candidates, restarts in mid-pass, gapped input and surplus beats each produce a result that differs from the plain case.

// File: rtl/sad9_array.sv
module sad9_array #(
  parameter int PIX_W = 8,
  parameter int LANES = 4,
  parameter int CANDS = 9,
  parameter int BEATS = 64,
  localparam int PSUM_W = PIX_W + $clog2(BEATS),
  localparam int COST_W = PSUM_W + $clog2(LANES),
  localparam int IDX_W = $clog2(CANDS)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [CANDS-1:0]          cand_inv,
  input  logic                      in_valid,
  input  logic [LANES*PIX_W-1:0]    cur_pix,
  input  logic [LANES*CANDS*PIX_W-1:0] ref_pix,
  output logic                      res_valid,
  output logic [CANDS*COST_W-1:0]   cost_flat,
  output logic [IDX_W-1:0]          best_idx,
  output logic [COST_W-1:0]         best_cost
);
  localparam int CNT_W = $clog2(BEATS + 1);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(BEATS - 1);
  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(BEATS);

  logic [CNT_W-1:0]  cnt;
  logic [CANDS-1:0]  inv_q;
  logic              fin1, fin2;
  logic [PSUM_W-1:0] psum [LANES*CANDS];
  logic [COST_W-1:0] tot  [CANDS];
  logic [COST_W-1:0] cost_q [CANDS];
  logic [IDX_W-1:0]  mi;
  logic [COST_W-1:0] mc;

  wire take = in_valid && !start && (cnt < FULL_C);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= FULL_C;
      inv_q <= '0;
      fin1 <= 1'b0;
      fin2 <= 1'b0;
      res_valid <= 1'b0;
    end else begin
      if (start) begin
        cnt <= '0;
        inv_q <= cand_inv;
      end else if (take) begin
        cnt <= cnt + 1'b1;
      end
      fin1 <= take && (cnt == LAST_C);
      fin2 <= fin1;
      res_valid <= fin2;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    for (genvar c = 0; c < CANDS; c++) begin : g_pe
      wire [PIX_W-1:0] a = cur_pix[l*PIX_W +: PIX_W];
      wire [PIX_W-1:0] b = ref_pix[(l*CANDS+c)*PIX_W +: PIX_W];
      wire [PIX_W-1:0] d = (a > b) ? (a - b) : (b - a);
      always_ff @(posedge clk) begin
        if (rst || start) psum[l*CANDS+c] <= '0;
        else if (take) psum[l*CANDS+c] <= psum[l*CANDS+c] + PSUM_W'(d);
      end
    end
  end

  always_comb begin
    for (int c = 0; c < CANDS; c++) begin
      tot[c] = '0;
      for (int l = 0; l < LANES; l++) tot[c] = tot[c] + COST_W'(psum[l*CANDS+c]);
    end
  end

  for (genvar c = 0; c < CANDS; c++) begin : g_cost
    always_ff @(posedge clk) begin
      if (rst) cost_q[c] <= '0;
      else if (fin1) cost_q[c] <= inv_q[c] ? {COST_W{1'b1}} : tot[c];
    end
    assign cost_flat[c*COST_W +: COST_W] = cost_q[c];
  end

  always_comb begin
    mi = '0;
    mc = cost_q[0];
    for (int c = 1; c < CANDS; c++) begin
      if (cost_q[c] < mc) begin
        mi = IDX_W'(c);
        mc = cost_q[c];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      best_idx <= '0;
      best_cost <= '0;
    end else if (fin2) begin
      best_idx <= mi;
      best_cost <= mc;
    end
  end
endmodule

// File: rtl/sad9_array_chk.sv
module sad9_array_chk #(
  parameter int CANDS = 9,
  parameter int COST_W = 16,
  parameter int IDX_W = 4,
  parameter int MAX_REAL = 65280
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    res_valid,
  input logic [CANDS*COST_W-1:0] cost_flat,
  input logic [IDX_W-1:0]        best_idx,
  input logic [COST_W-1:0]       best_cost,
  input logic [CANDS-1:0]        inv_q
);
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid); // R3

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (best_idx < IDX_W'(CANDS))); // R4

  AST_BEST_MATCH: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (best_cost == cost_flat[best_idx*COST_W +: COST_W])); // R4

  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (rst)
    $past(res_valid) |-> $stable(best_idx) && $stable(best_cost)); // R4

  for (genvar c = 0; c < CANDS; c++) begin : g_c
    AST_BEST_MIN: assert property (@(posedge clk) disable iff (rst)
      res_valid |-> (best_cost <= cost_flat[c*COST_W +: COST_W])); // R4
    AST_TIE_LOW: assert property (@(posedge clk) disable iff (rst)
      (res_valid && (c < best_idx)) |-> (cost_flat[c*COST_W +: COST_W] > best_cost)); // R4
    AST_INV_MAX: assert property (@(posedge clk) disable iff (rst)
      (res_valid && inv_q[c]) |-> (cost_flat[c*COST_W +: COST_W] == {COST_W{1'b1}})); // R5
    AST_COST_RANGE: assert property (@(posedge clk) disable iff (rst)
      (res_valid && !inv_q[c]) |-> (cost_flat[c*COST_W +: COST_W] <= COST_W'(MAX_REAL))); // R2
  end
endmodule

bind sad9_array sad9_array_chk #(
  .CANDS(CANDS), .COST_W(COST_W), .IDX_W(IDX_W),
  .MAX_REAL(LANES * BEATS * ((1 << PIX_W) - 1))
) u_chk (
  .clk(clk), .rst(rst), .res_valid(res_valid), .cost_flat(cost_flat),
  .best_idx(best_idx), .best_cost(best_cost), .inv_q(inv_q)
);

// File: tb/tb_sad9_array.sv
module tb_sad9_array;
  localparam int L = 4, C = 9, N = 64;

  logic clk = 0, rst = 1, start = 0, in_valid = 0;
  logic [C-1:0] cand_inv = '0;
  logic [L*8-1:0] cur_pix = '0;
  logic [L*C*8-1:0] ref_pix = '0;
  logic res_valid;
  logic [C*16-1:0] cost_flat;
  logic [3:0] best_idx;
  logic [15:0] best_cost;

  sad9_array dut (.clk(clk), .rst(rst), .start(start), .cand_inv(cand_inv),
    .in_valid(in_valid), .cur_pix(cur_pix), .ref_pix(ref_pix), .res_valid(res_valid),
    .cost_flat(cost_flat), .best_idx(best_idx), .best_cost(best_cost));

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  int acc [C];
  int snap [C];
  logic [C-1:0] inv_m = '0, snap_inv = '0;
  int cnt = N, pend = 0, exp_idx = 0, exp_cost = 0;
  bit exp_valid = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      cnt = N; pend = 0; exp_valid = 0; inv_m = '0;
      foreach (acc[i]) acc[i] = 0;
    end else begin
      exp_valid = 0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) exp_valid = 1;
      end
      if (start) begin
        cnt = 0; inv_m = cand_inv;
        foreach (acc[i]) acc[i] = 0;
      end else if (in_valid && cnt < N) begin
        for (int l = 0; l < L; l++)
          for (int c = 0; c < C; c++) begin
            int a, b;
            a = cur_pix[l*8 +: 8];
            b = ref_pix[(l*C+c)*8 +: 8];
            acc[c] += (a > b) ? a - b : b - a;
          end
        cnt++;
        if (cnt == N) begin
          snap_inv = inv_m;
          exp_idx = 0; exp_cost = 65536;
          for (int c = 0; c < C; c++) begin
            snap[c] = inv_m[c] ? 65535 : acc[c];
            if (snap[c] < exp_cost) begin exp_cost = snap[c]; exp_idx = c; end
          end
          pend = 2;
        end
      end
    end
  end

  always @(negedge clk) if (!rst) begin
    chk(res_valid == exp_valid, "R3 res_valid", res_valid, exp_valid);
    if (exp_valid) begin
      for (int c = 0; c < C; c++)
        chk(cost_flat[c*16 +: 16] == snap[c], snap_inv[c] ? "R5 cost" : "R2 cost",
            cost_flat[c*16 +: 16], snap[c]);
      chk(best_idx == exp_idx, "R4 best_idx", best_idx, exp_idx);
      chk(best_cost == exp_cost, "R4 best_cost", best_cost, exp_cost);
    end
  end

  // kind 0 random, 1 equal on eqm else off by one, 2 maximal difference
  task automatic drive(input bit v, input int kind, input logic [C-1:0] eqm);
    in_valid = v;
    for (int l = 0; l < L; l++) begin
      logic [7:0] p;
      p = (kind == 2) ? 8'hFF : 8'($urandom);
      cur_pix[l*8 +: 8] = p;
      for (int c = 0; c < C; c++)
        ref_pix[(l*C+c)*8 +: 8] = (kind == 0) ? 8'($urandom) :
                                  (kind == 2) ? 8'h00 :
                                  (eqm[c] ? p : p ^ 8'h01);
    end
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic pass(input int kind, input logic [C-1:0] eqm, input logic [C-1:0] inv,
                      input bit gaps, input int beats);
    start = 1; cand_inv = inv;
    drive(1, kind, eqm);   // R6: beat alongside start is not taken
    start = 0;
    for (int i = 0; i < beats; i++) begin
      if (gaps && (i % 5 == 2)) drive(0, kind, eqm);  // R7 idle gap
      drive(1, kind, eqm);
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(res_valid == 0, "R1 res_valid", res_valid, 0);
    chk(cost_flat == '0, "R1 costs", 0, 0);
    chk(best_idx == 0 && best_cost == 0, "R1 best", best_cost, 0);
    // R7: beats before any start are ignored
    for (int i = 0; i < 70; i++) drive(1, 0, '0);
    pass(0, '0, '0, 0, N);                        // R2 random
    pass(0, '0, '0, 1, N + 6);                    // R7 gaps and surplus beats
    pass(1, 9'b0_0100_0100, '0, 0, N);            // R4 tie, idx 2 wins
    pass(1, 9'b1_1111_1111, '0, 1, N);            // R4 all zero, idx 0
    pass(1, 9'b0_0010_0100, 9'b0_0000_0100, 0, N); // R5 true minimum masked
    pass(0, '0, 9'b1_1111_1111, 0, N);            // R5 all invalid
    pass(2, '0, '0, 0, N);                        // R2 largest cost 65280
    pass(2, '0, '0, 0, 30);                       // partial pass
    pass(0, '0, 9'b1_0000_0001, 0, N);            // R6 restart clears sums
    pass(1, 9'b1_0000_0000, '0, 1, N);            // R4 highest index wins alone
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule